// File: doc/BRIEF.md
# Spread-spectrum offset-QPSK half-sine baseband modulator

This block turns a stream of bytes into shaped baseband samples for a low-rate 2.4 GHz personal-area-network transmitter. Each byte is cut into two 4-bit data symbols, and the low nibble goes first. Each symbol selects one 32-chip pseudo-noise sequence from a 16-entry table given as a parameter. The chips of that sequence are issued one per chip period, starting with chip 0. Even chips go to the in-phase branch and odd chips go to the quadrature branch.

Every chip is sent as a signed half-sine pulse that spans two chip periods. Because the branches take turns, the quadrature branch trails the in-phase branch by one chip period. While data flows, one branch is always at the peak of its pulse when the other passes through zero, so the envelope stays constant.

The sample strobe sets the pace. Each strobe produces one signed sample pair, and a fixed number of strobes make up one chip period. When no byte is waiting, the pulses already in flight run to completion, the outputs settle at zero and an idle flag goes high. The next byte then starts a new pulse on the first strobe after it is accepted.

Top module: `dsss_hs_modulator`

## Requirements
- R1: The low nibble of a byte is spread before its high nibble. Each nibble value s selects table entry s, which is bits [32s+31:32s] of CHIP_TAB. Bit k of an entry is chip k, and chips go out in the order 0 to 31.
- R2: Chip k of the stream starts in chip period k. Even k loads the I branch and odd k loads the Q branch. A loaded pulse lasts exactly two chip periods, and a branch that is not carrying a pulse outputs 0.
- R3: Sample n (0 to 2·SPC−1) of a pulse has magnitude round(2047·sin(π·n/(2·SPC))). The sign is positive for a chip value of 1 and negative for a chip value of 0.
- R4: Each cycle with smp_stb_i high produces one sample pair on i_o/q_o in the following cycle, and SPC strobes make one chip period. out_valid_o is high for exactly that one cycle whenever a branch is active. Between strobes, i_o and q_o hold their values.
- R5: byte_ready_o is high only when no accepted byte is waiting and no byte still has chips left to issue. It therefore rises once the last chip of the high nibble has been issued, and it falls in the cycle after a byte is accepted.
- R6: A byte accepted before the next chip-period boundary continues the chip stream with no gap. In that case its chip 0 follows the previous byte's chip 31 in the very next period.
- R7: With no byte available, the pulses in flight finish, then out_valid_o stays low, i_o and q_o are 0 and idle_o is high. idle_o is updated on strobes.
- R8: After reset, byte_ready_o and idle_o are 1, out_valid_o is 0, and i_o and q_o are 0.
- R9: A byte accepted while idle starts chip period 0 on the next strobe. The first valid sample pair after idle is I = 0 and Q = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 2·SYM_W | Data byte |
| byte_valid_i | input | 1 | Byte offered |
| byte_ready_o | output | 1 | Byte can be taken this cycle |
| smp_stb_i | input | 1 | One output sample per pulse of this strobe |
| i_o | output | AMP_W | Signed in-phase sample |
| q_o | output | AMP_W | Signed quadrature sample |
| out_valid_o | output | 1 | New sample pair this cycle |
| idle_o | output | 1 | No pulse active |

## Verification
The bench goes after the handover at the end of a byte, where a new byte may arrive during the last chip period of the high nibble. If ready opens too late, a gap appears in the stream. If it opens too early, chips from the old byte are lost. It also covers drain and restart. A design that left a branch active one period too long would emit a stray pulse half. One that kept counting samples while idle would start the next byte partway through a pulse, with a sample that is not zero. Random strobe spacing shows whether the outputs hold between strobes. A table with unrelated entries exposes a nibble-order or chip-order swap as wrong signs.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

  localparam int unsigned DEF_SYMS  = 16;
  localparam int unsigned DEF_CHIPS = 32;

  // Base pattern, entries 1..7 rotate it by 4 chips each, 8..15 flip odd chips.
  function automatic logic [DEF_SYMS*DEF_CHIPS-1:0] def_tab();
    logic [31:0] base;
    logic [31:0] r;
    logic [DEF_SYMS*DEF_CHIPS-1:0] t;
    base = 32'h744A_C39B;
    t = '0;
    for (int s = 0; s < 8; s++) begin
      r = (s == 0) ? base : ((base << (4*s)) | (base >> (32 - 4*s)));
      t[s*32 +: 32]     = r;
      t[(s+8)*32 +: 32] = r ^ 32'hAAAA_AAAA;
    end
    return t;
  endfunction

  localparam logic [DEF_SYMS*DEF_CHIPS-1:0] DEF_TAB = def_tab();

  function automatic int hs_sample(int n, int spc, int amp);
    real x;
    x = amp * $sin(3.14159265358979 * n / (2.0 * spc));
    return $rtoi(x + 0.5);
  endfunction

endpackage

// File: rtl/hsm_rom.sv
module hsm_rom #(
  parameter int unsigned SPC   = 4,
  parameter int unsigned AMP_W = 12,
  localparam int unsigned N    = 2 * SPC,
  localparam int unsigned IW   = $clog2(N)
) (
  input  logic [IW-1:0]    idx_i,
  output logic [AMP_W-1:0] mag_o
);
  localparam int AMP = (1 << (AMP_W - 1)) - 1;

  logic [AMP_W-1:0] tab [2**IW];

  for (genvar k = 0; k < 2**IW; k++) begin : g_tab
    localparam int V = (k < N) ? hsm_pkg::hs_sample(k, SPC, AMP) : 0;
    assign tab[k] = AMP_W'(V);
  end

  assign mag_o = tab[idx_i];
endmodule

// File: rtl/hsm_branch.sv
module hsm_branch #(
  parameter int unsigned SPC   = 4,
  parameter int unsigned AMP_W = 12,
  localparam int unsigned SW   = $clog2(SPC),
  localparam int unsigned IW   = $clog2(2 * SPC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    stb_i,
  input  logic                    per_i,
  input  logic                    load_i,
  input  logic                    chip_i,
  input  logic [SW-1:0]           samp_i,
  output logic signed [AMP_W-1:0] smp_o,
  output logic                    act_n_o,
  output logic                    cont_o
);
  logic act_q, half_q, chip_q;
  logic act_d, half_d, chip_d;
  logic [IW-1:0] idx;
  logic [AMP_W-1:0] mag;
  logic signed [AMP_W-1:0] smp_d, smp_q;

  always_comb begin
    act_d  = act_q;
    half_d = half_q;
    chip_d = chip_q;
    if (per_i) begin
      if (load_i) begin
        act_d  = 1'b1;
        half_d = 1'b0;
        chip_d = chip_i;
      end else if (act_q && !half_q) begin
        half_d = 1'b1;
      end else begin
        act_d = 1'b0;
      end
    end
  end

  assign idx = half_d ? (IW'(SPC) + IW'(samp_i)) : IW'(samp_i);

  hsm_rom #(.SPC(SPC), .AMP_W(AMP_W)) rom_i (.idx_i(idx), .mag_o(mag));

  always_comb begin
    if (!act_d)      smp_d = '0;
    else if (chip_d) smp_d = $signed(mag);
    else             smp_d = -$signed(mag);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
      chip_q <= 1'b0;
      smp_q  <= '0;
    end else if (stb_i) begin
      act_q  <= act_d;
      half_q <= half_d;
      chip_q <= chip_d;
      smp_q  <= smp_d;
    end
  end

  assign smp_o   = smp_q;
  assign act_n_o = act_d;
  assign cont_o  = act_q && !half_q;

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stb_i) |-> $stable(smp_o));

  p_start_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> (smp_o == '0));

  p_two_periods_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_i && act_q && half_q && !load_i) |=> !act_q);
endmodule

// File: rtl/hsm_seq.sv
module hsm_seq #(
  parameter int unsigned N_CHIP = 32,
  parameter int unsigned SYM_W  = 4,
  parameter int unsigned SPC    = 4,
  parameter logic [(1<<SYM_W)*N_CHIP-1:0] CHIP_TAB = hsm_pkg::DEF_TAB,
  localparam int unsigned BYTE_W = 2 * SYM_W,
  localparam int unsigned CW     = $clog2(N_CHIP),
  localparam int unsigned SW     = $clog2(SPC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic              cont_i,
  output logic              per_o,
  output logic [1:0]        load_o,
  output logic              chip_o,
  output logic [SW-1:0]     samp_o
);
  logic [BYTE_W-1:0] byte_q;
  logic ld_q, run_q, nib_q;
  logic [CW-1:0] cidx_q;
  logic [SW-1:0] samp_q;
  logic have, issue, last, accept;
  logic [SYM_W-1:0] sym;
  logic [N_CHIP-1:0] entry;

  assign have   = run_q || ld_q;
  assign sym    = nib_q ? byte_q[BYTE_W-1:SYM_W] : byte_q[SYM_W-1:0];
  assign entry  = CHIP_TAB[int'(sym)*N_CHIP +: N_CHIP];
  assign chip_o = entry[cidx_q];
  assign per_o  = stb_i && (samp_q == '0);
  assign issue  = per_o && have;
  assign load_o = issue ? (2'b01 << cidx_q[0]) : 2'b00;
  assign last   = nib_q && (cidx_q == CW'(N_CHIP - 1));
  assign byte_ready_o = !ld_q && !run_q;
  assign accept = byte_valid_i && byte_ready_o;
  assign samp_o = samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      ld_q   <= 1'b0;
      run_q  <= 1'b0;
      nib_q  <= 1'b0;
      cidx_q <= '0;
      samp_q <= '0;
    end else begin
      if (accept) begin
        byte_q <= byte_i;
        ld_q   <= 1'b1;
      end
      if (issue) begin
        if (!run_q) ld_q <= 1'b0;
        if (last) begin
          run_q  <= 1'b0;
          nib_q  <= 1'b0;
          cidx_q <= '0;
        end else begin
          run_q <= 1'b1;
          if (cidx_q == CW'(N_CHIP - 1)) begin
            nib_q  <= 1'b1;
            cidx_q <= '0;
          end else begin
            cidx_q <= cidx_q + CW'(1);
          end
        end
      end
      if (stb_i) begin
        if (per_o && !have && !cont_i)       samp_q <= '0;  // idle: stay aligned
        else if (samp_q == SW'(SPC - 1))     samp_q <= '0;
        else                                 samp_q <= samp_q + SW'(1);
      end
    end
  end

  p_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_ready_o) |=> !byte_ready_o);

  p_first_chip_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && !run_q) |-> (cidx_q == '0 && !nib_q));

  p_samp_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(samp_q));
endmodule

// File: rtl/dsss_hs_modulator.sv
module dsss_hs_modulator #(
  parameter int unsigned N_CHIP = 32,
  parameter int unsigned SYM_W  = 4,
  parameter int unsigned SPC    = 4,
  parameter int unsigned AMP_W  = 12,
  parameter logic [(1<<SYM_W)*N_CHIP-1:0] CHIP_TAB = hsm_pkg::DEF_TAB,
  localparam int unsigned BYTE_W = 2 * SYM_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic                    byte_valid_i,
  output logic                    byte_ready_o,
  input  logic                    smp_stb_i,
  output logic signed [AMP_W-1:0] i_o,
  output logic signed [AMP_W-1:0] q_o,
  output logic                    out_valid_o,
  output logic                    idle_o
);
  localparam int unsigned SW = $clog2(SPC);

  logic per;
  logic [1:0] load, act_n, cont;
  logic chip;
  logic [SW-1:0] samp;
  logic signed [AMP_W-1:0] smp [2];
  logic valid_q, idle_q;

  hsm_seq #(.N_CHIP(N_CHIP), .SYM_W(SYM_W), .SPC(SPC), .CHIP_TAB(CHIP_TAB)) seq_i (
    .clk_i, .rst_ni, .stb_i(smp_stb_i), .byte_i, .byte_valid_i, .byte_ready_o,
    .cont_i(|cont), .per_o(per), .load_o(load), .chip_o(chip), .samp_o(samp)
  );

  // branch 0 = I (even chips), branch 1 = Q (odd chips)
  for (genvar g = 0; g < 2; g++) begin : g_br
    hsm_branch #(.SPC(SPC), .AMP_W(AMP_W)) br_i (
      .clk_i, .rst_ni, .stb_i(smp_stb_i), .per_i(per), .load_i(load[g]),
      .chip_i(chip), .samp_i(samp), .smp_o(smp[g]), .act_n_o(act_n[g]),
      .cont_o(cont[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idle_q  <= 1'b1;
    end else begin
      valid_q <= smp_stb_i && (|act_n);
      if (smp_stb_i) idle_q <= !(|act_n);
    end
  end

  assign i_o         = smp[0];
  assign q_o         = smp[1];
  assign out_valid_o = valid_q;
  assign idle_o      = idle_q;

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (i_o == '0 && q_o == '0 && !out_valid_o));

  p_valid_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(smp_stb_i));

  p_one_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({g_br[0].br_i.act_n_o && !g_br[0].br_i.act_q,
              g_br[1].br_i.act_n_o && !g_br[1].br_i.act_q} & {2{per}}));
endmodule

// File: tb/dsss_hs_modulator_tb_top.sv
`timescale 1ns/1ps
module dsss_hs_modulator_tb_top;
  localparam int SPC = 4;
  localparam int AMP = 2047;

  function automatic logic [511:0] tb_tab();
    logic [31:0] x;
    logic [511:0] t;
    x = 32'h1234_5678;
    for (int s = 0; s < 16; s++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      t[s*32 +: 32] = x;
    end
    return t;
  endfunction

  localparam logic [511:0] TAB = tb_tab();

  logic clk = 1'b0;
  logic rst_ni;
  logic [7:0] byte_d;
  logic vld, stb;
  logic rdy, ovld, idl;
  logic signed [11:0] i_s, q_s;

  always #2 clk = ~clk;

  dsss_hs_modulator #(.SPC(SPC), .CHIP_TAB(TAB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .byte_i(byte_d), .byte_valid_i(vld),
    .byte_ready_o(rdy), .smp_stb_i(stb), .i_o(i_s), .q_o(q_s),
    .out_valid_o(ovld), .idle_o(idl)
  );

  int checks = 0;
  int errors = 0;
  int ref_tab [2*SPC];

  bit m_ld, m_run, m_nib;
  int m_cidx, m_samp;
  logic [7:0] m_byte;
  bit m_act [2];
  bit m_half [2];
  bit m_chip [2];
  int exp_s [2];
  bit exp_v, exp_idle;

  task automatic chk(int act, int exp, string what, string ph);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s (phase %s) act %0d exp %0d", what, "", ph, act, exp);
    end
  endtask

  task automatic check_all(string ph);
    chk(int'(i_s), exp_s[0], "R3 i_o", ph);
    chk(int'(q_s), exp_s[1], "R3 q_o", ph);
    chk(int'(ovld), int'(exp_v), "R4 out_valid_o", ph);
    chk(int'(rdy), int'(!m_ld && !m_run), "R5 byte_ready_o", ph);
    chk(int'(idl), int'(exp_idle), "R7 idle_o", ph);
  endtask

  task automatic step_model(bit s, bit v, logic [7:0] d);
    bit acc;
    bit per, have;
    acc = v && !m_ld && !m_run;
    exp_v = 1'b0;
    if (s) begin
      per  = (m_samp == 0);
      have = m_run || m_ld;
      if (per) begin
        for (int br = 0; br < 2; br++) begin
          if (have && ((m_cidx % 2) == br)) begin
            int sym;
            sym = m_nib ? int'(m_byte[7:4]) : int'(m_byte[3:0]);
            m_act[br] = 1'b1; m_half[br] = 1'b0;
            m_chip[br] = TAB[sym*32 + m_cidx];
          end else if (m_act[br] && !m_half[br]) begin
            m_half[br] = 1'b1;
          end else begin
            m_act[br] = 1'b0;
          end
        end
        if (have) begin
          if (!m_run) m_ld = 1'b0;
          if (m_nib && m_cidx == 31) begin
            m_run = 1'b0; m_nib = 1'b0; m_cidx = 0;
          end else begin
            m_run = 1'b1;
            if (m_cidx == 31) begin m_nib = 1'b1; m_cidx = 0; end
            else m_cidx++;
          end
        end
      end
      for (int br = 0; br < 2; br++) begin
        int r;
        r = ref_tab[(m_half[br] ? SPC : 0) + m_samp];
        exp_s[br] = !m_act[br] ? 0 : (m_chip[br] ? r : -r);
      end
      exp_v    = m_act[0] || m_act[1];
      exp_idle = !(m_act[0] || m_act[1]);
      if (per && !(m_act[0] || m_act[1])) m_samp = 0;
      else m_samp = (m_samp + 1) % SPC;
    end
    if (acc) begin
      m_byte = d;
      m_ld = 1'b1;
    end
  endtask

  task automatic run_cyc(bit s, bit v, logic [7:0] d, string ph);
    stb = s; vld = v; byte_d = d;
    step_model(s, v, d);
    @(posedge clk);
    @(negedge clk);
    check_all(ph);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog act running exp finished");
    summary();
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int n = 0; n < 2*SPC; n++)
      ref_tab[n] = $rtoi(AMP * $sin(3.14159265358979 * n / (2.0 * SPC)) + 0.5);
    m_ld = 0; m_run = 0; m_nib = 0; m_cidx = 0; m_samp = 0; m_byte = 0;
    for (int br = 0; br < 2; br++) begin
      m_act[br] = 0; m_half[br] = 0; m_chip[br] = 0; exp_s[br] = 0;
    end
    exp_v = 0; exp_idle = 1;
    rst_ni = 1'b0; stb = 0; vld = 0; byte_d = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R8");

    // R1: one byte, strobe every other cycle, then R7 drain to idle
    run_cyc(1'b0, 1'b1, 8'hA5, "R1");
    for (int k = 0; k < 540; k++) run_cyc(k[0] == 1'b0, 1'b0, 8'h00, "R1");
    for (int k = 0; k < 60; k++)  run_cyc(k[0] == 1'b0, 1'b0, 8'h00, "R7");
    chk(int'(idl), 1, "R7 idle after drain", "R7");

    // R9: restart from idle, first sample pair is zero
    run_cyc(1'b0, 1'b1, 8'h3C, "R9");
    run_cyc(1'b1, 1'b0, 8'h00, "R9");
    chk(int'(ovld), 1, "R9 first valid", "R9");
    chk(int'(i_s), 0, "R9 first i", "R9");
    chk(int'(q_s), 0, "R9 first q", "R9");
    for (int k = 0; k < 400; k++) run_cyc(1'b1, 1'b0, 8'h00, "R9");

    // R6: back-to-back bytes, including all-zero and all-one
    for (int k = 0; k < 1500; k++) begin
      logic [7:0] d;
      d = (k < 300) ? 8'h00 : (k < 600) ? 8'hFF : 8'($urandom);
      run_cyc(1'b1, 1'b1, d, "R6");
    end
    for (int k = 0; k < 300; k++) run_cyc(1'b1, 1'b0, 8'h00, "R7");

    // R2: random strobe spacing and data gaps
    for (int k = 0; k < 20000; k++) begin
      bit gap;
      gap = ((k / 700) % 4) == 3;
      run_cyc(($urandom % 3) != 0, !gap && (($urandom % 8) < 5), 8'($urandom), "R2");
    end

    summary();
    $finish;
  end
endmodule